// File: doc/BRIEF.md
# Interleaved Overlapped Read Controller

This controller streams a run of sequential words out of eight memory banks that share one address bus and one data bus. The banks are interleaved on the low address bits, so neighbouring addresses always live in different banks. A requester hands over a start address and a burst length. The controller then puts one address on the bus in every cycle and pulses the latch strobe of the bank that holds it. Each bank stores its address and finishes a fixed-latency read on its own, so the bank reads overlap instead of running one after another.

The banks are passive and give no acknowledge. Because the read latency is a known constant, the controller keeps a short delay line of pending reads. That line tells it in which cycle a word is on the shared data bus, and the word is taken then. Words leave on a valid-qualified output stream in strictly ascending address order. A single-cycle done pulse closes each burst, and only then does the controller take the next request.

Top module: `ilv_read_ctrl`

## Requirements
- R1: While reset is held, and right after it, `reqReady` is 1 and `bankLatch`, `outValid` and `done` are 0.
- R2: A request is taken only at a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` is 0 from the cycle after acceptance until the burst ends. A `reqValid` raised while busy has no effect on the addresses issued or the words delivered.
- R3: The first address is driven in the cycle right after acceptance. One address follows in every cycle, with issue i carrying start+i. In each issue cycle exactly one `bankLatch` bit is high: bit k, where k is the value of `busAddr[2:0]`.
- R4: A burst issues and delivers exactly `reqLenM1`+1 words, from 1 up to 256.
- R5: The word for an address issued in cycle t is sampled from `busData` in cycle t+LATENCY and shows on `outData` with `outValid` in cycle t+LATENCY+1.
- R6: Delivered words come in ascending address order in consecutive cycles, with no gaps inside a burst.
- R7: `done` is high for exactly one cycle, the cycle after the last word, and `outValid` is 0 in that cycle.
- R8: `reqReady` returns to 1 in the cycle after `done`.
- R9: Issued addresses wrap modulo 2^ADDR_W, so a burst that crosses the top of the address space continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Burst request present |
| reqAddr | input | ADDR_W | First word address of the burst |
| reqLenM1 | input | LEN_W | Burst length minus one |
| reqReady | output | 1 | Controller idle, request may be taken |
| busAddr | output | ADDR_W | Shared bank address bus |
| bankLatch | output | NUM_BANKS | Per-bank address latch strobes, one-hot |
| busData | input | DATA_W | Shared bank read data bus |
| outValid | output | 1 | Output word valid |
| outData | output | DATA_W | Output word |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
Bank models in the bench return a word computed from the address after a latency of five cycles. This catches any capture one cycle early or late, and any word taken out of order. Single-word and 256-word bursts test the ends of the length range. Unaligned starts show that the bank rotation follows the address rather than the burst position. A start near the top of the space checks the wrap. Random starts and lengths, with stray requests raised while busy, separate a controller that ignores busy requests from one that restarts on them.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // strobes handed from the sequencer to the capture datapath
  typedef struct packed {
    logic issue;  // an address is on the bus this cycle
    logic last;   // it is the final address of the burst
  } ctrlStrobe_t;
endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int NUM_BANKS = 8,
  parameter int LEN_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLenM1,
  input  logic                 done,
  output logic                 reqReady,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [NUM_BANKS-1:0] bankLatch,
  output ctrlStrobe_t          stb
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_DRAIN} state_t;
  state_t state;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curAddr <= '0;
      remain  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) begin
          curAddr <= reqAddr;
          remain  <= reqLenM1;
          state   <= S_ISSUE;
        end
        S_ISSUE: begin
          curAddr <= curAddr + 1'b1;
          if (remain == '0) state <= S_DRAIN;
          else remain <= remain - 1'b1;
        end
        S_DRAIN: if (done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady  = (state == S_IDLE);
  assign stb.issue = (state == S_ISSUE);
  assign stb.last  = stb.issue && (remain == '0);
  assign busAddr   = stb.issue ? curAddr : '0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_latch
    assign bankLatch[b] = stb.issue && (curAddr[BANK_W-1:0] == BANK_W'(b));
  end

  // R3: never more than one bank strobed
  assert_onehot_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankLatch));
  // R3 / R9: successive issues step the address by one, wrapping
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.issue && !stb.last) |=> (stb.issue && busAddr == ADDR_W'($past(busAddr) + 1'b1)));
  // R2: nothing is issued while idle
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (bankLatch == '0));
  // R8: back to idle right after the done pulse
  assert_ready_after_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);
endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [DATA_W-1:0] busData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              done
);
  localparam int TAP = LATENCY - 1;

  logic [LATENCY-1:0] pendValid;
  logic [LATENCY-1:0] pendLast;
  logic               outLast;

  // delay line: stage TAP is high in the cycle the bank drives the bus
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= '0;
      pendLast  <= '0;
    end else begin
      for (int i = 0; i < LATENCY; i++) begin
        if (i == 0) begin
          pendValid[0] <= stb.issue;
          pendLast[0]  <= stb.last;
        end else begin
          pendValid[i] <= pendValid[i-1];
          pendLast[i]  <= pendLast[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outData  <= '0;
      done     <= 1'b0;
    end else begin
      outValid <= pendValid[TAP];
      outLast  <= pendValid[TAP] && pendLast[TAP];
      if (pendValid[TAP]) outData <= busData;
      done     <= outValid && outLast;
    end
  end

  // R7: done lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: no word accompanies the done pulse
  assert_done_no_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);
endmodule

// File: rtl/ilv_read_ctrl.sv
module ilv_read_ctrl
  import ilv_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 8,
  parameter int LATENCY   = 4,
  parameter int MAX_BURST = 256,
  localparam int LEN_W    = $clog2(MAX_BURST)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLenM1,
  output logic                 reqReady,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [NUM_BANKS-1:0] bankLatch,
  input  logic [DATA_W-1:0]    busData,
  output logic                 outValid,
  output logic [DATA_W-1:0]    outData,
  output logic                 done
);
  ctrlStrobe_t stb;

  ilv_ctrl #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLenM1(reqLenM1), .done(done), .reqReady(reqReady),
    .busAddr(busAddr), .bankLatch(bankLatch), .stb(stb)
  );

  ilv_datapath #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busData(busData),
    .outValid(outValid), .outData(outData), .done(done)
  );

  // R3: an accepted request issues in the very next cycle
  assert_first_issue_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (bankLatch != '0));
endmodule

// File: tb/ilv_read_ctrl_bench.sv
module ilv_read_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 20;
  localparam int DW  = 8;
  localparam int NB  = 8;
  localparam int LAT = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqLenM1 = '0;
  logic          reqReady;
  logic [AW-1:0] busAddr;
  logic [NB-1:0] bankLatch;
  logic [DW-1:0] busData;
  logic          outValid;
  logic [DW-1:0] outData;
  logic          done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  ilv_read_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(NB), .LATENCY(LAT), .MAX_BURST(256))
  u_ilv_read_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLenM1(reqLenM1), .reqReady(reqReady), .busAddr(busAddr),
    .bankLatch(bankLatch), .busData(busData), .outValid(outValid),
    .outData(outData), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mix(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h9};
  endfunction

  // bank models: latch on strobe, drive the bus LAT cycles after the issue cycle
  logic [AW-1:0] bAddr [NB];
  int            bCnt  [NB];
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (bankLatch[b]) begin
        bAddr[b] <= busAddr;
        bCnt[b]  <= LAT;
      end else if (bCnt[b] > 0) begin
        bCnt[b]  <= bCnt[b] - 1;
      end
    end
  end
  always_comb begin
    busData = '0;
    for (int b = 0; b < NB; b++)
      if (bCnt[b] == 1) busData = busData | mix(bAddr[b]);
  end
  initial for (int b = 0; b < NB; b++) begin bCnt[b] = 0; bAddr[b] = '0; end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
    end
  end

  task automatic runBurst(input logic [AW-1:0] start, input int lenM1, input bit poke);
    int driveCyc, nIss, nOut, firstIss, firstOut, lastOut, doneCyc;
    logic [AW-1:0] expIss, expOut;
    bit seenDone;
    nIss = 0; nOut = 0; firstIss = -1; firstOut = -1; lastOut = -1; doneCyc = -1;
    expIss = start; expOut = start; seenDone = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = start; reqLenM1 = 8'(lenM1); driveCyc = cyc;
    while (!seenDone) begin
      @(negedge clk);
      if (cyc == driveCyc + 1 && poke) begin
        check(!reqReady, "R2 busy reqReady", reqReady, 0);
        reqValid = 1'b1; reqAddr = ~start; reqLenM1 = 8'd3;
      end else begin
        reqValid = 1'b0;
      end
      if (bankLatch != '0) begin
        if (nIss == 0) firstIss = cyc;
        check(busAddr == expIss, "R3/R9 busAddr", busAddr, expIss);
        check(bankLatch == (8'(1) << busAddr[2:0]), "R3 bankLatch", bankLatch, 8'(1) << busAddr[2:0]);
        expIss = expIss + 1'b1; nIss++;
      end
      if (outValid) begin
        if (nOut == 0) firstOut = cyc;
        lastOut = cyc;
        check(outData == mix(expOut), "R6 outData order", outData, mix(expOut));
        expOut = expOut + 1'b1; nOut++;
      end
      if (done) begin
        doneCyc = cyc; seenDone = 1;
        check(!outValid, "R7 no word with done", outValid, 0);
      end
    end
    check(nIss == lenM1 + 1, "R4 issue count", nIss, lenM1 + 1);
    check(nOut == lenM1 + 1, "R4 word count", nOut, lenM1 + 1);
    check(firstIss == driveCyc + 1, "R3 first issue cycle", firstIss, driveCyc + 1);
    check(firstOut == firstIss + LAT + 1, "R5 first word cycle", firstOut, firstIss + LAT + 1);
    check(lastOut - firstOut == lenM1, "R6 contiguous words", lastOut - firstOut, lenM1);
    check(doneCyc == lastOut + 1, "R7 done timing", doneCyc, lastOut + 1);
    @(negedge clk);
    check(!done, "R7 done single pulse", done, 0);
    check(reqReady, "R8 ready after done", reqReady, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqReady && bankLatch == '0 && !outValid && !done, "R1 in reset",
          {reqReady, bankLatch, outValid, done}, {1'b1, 8'h00, 2'b00});
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && bankLatch == '0 && !outValid && !done, "R1 after reset",
          {reqReady, bankLatch, outValid, done}, {1'b1, 8'h00, 2'b00});
    runBurst(20'h00000, 0, 1'b0);      // single word
    runBurst(20'h00010, 7, 1'b1);      // one full bank rotation, busy poke
    runBurst(20'h00105, 12, 1'b1);     // unaligned start
    runBurst(20'hFFFFD, 5, 1'b0);      // R9 wrap
    runBurst(20'h3A000, 255, 1'b1);    // maximum length
    for (int n = 0; n < 20; n++)
      runBurst(AW'($urandom), $urandom_range(0, 24), 1'($urandom));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule